// File: doc/BRIEF.md
# Real-Time Clock Alarm Controller

This block watches the running time of a real-time clock and raises an alarm when it matches a programmed setting. Seconds, minutes, hours and day of month arrive in BCD with a single-cycle pulse that marks each new second. The match is only evaluated on that pulse. Four alarm registers each hold one time field, and the top bit of each is a repeat bit. Together the four repeat bits choose how often the alarm fires: every second, every minute, every hour, every day or once a month.

A match sets an alarm flag in a flags register. The flag can drive an active-low, open-drain style interrupt. The flags register also holds the interrupt enable and the battery-mode interrupt enable. Reading the flags register clears the flag and releases the interrupt. A match that arrives while the flags register address is latched is held back, so a read in progress cannot swallow it. The flag is set as soon as the address moves elsewhere.

A power-up indication clears both enables but leaves the matching running. An alarm during power-up therefore only records the flag.

Top module: `rtc_alarm_top`

## Requirements
- R1: After `rstN` is low, all four alarm registers and the flags register read 0x00 and `irqPullLow` is 0.
- R2: Alarm registers are read and written at these addresses, each with its repeat bit in bit 7:
  - seconds at 0x1FF2
  - minutes at 0x1FF3
  - hours at 0x1FF4
  - day of month at 0x1FF5

  The flags register at 0x1FF0 reads as follows:
  - bit 7: interrupt enable
  - bit 6: alarm flag
  - bit 5: battery-mode interrupt enable
  - all other bits: 0

  A write to 0x1FF0 loads bits 7 and 5 only and never changes the alarm flag. Any other address reads 0x00.
- R3: With repeat bits (date, hour, minute, second) = 1111, every seconds pulse sets the flag. Any code not named in R4 or R5 behaves the same way.
- R4: Code 1110 requires the seconds to match. Code 1100 requires seconds and minutes to match. Code 1000 requires seconds, minutes and hours to match.
- R5: Code 0000 requires all four fields to match (seconds 7 bits, minutes 7 bits, hours 6 bits, date 6 bits).
- R6: With all repeat bits 0 and the date field 0, no match ever occurs, even when the time reads all zero.
- R7: A match is taken only in a cycle where `tickPulse` is 1. The flag reads 1 from the clock edge that samples that pulse onward.
- R8: A read strobe at 0x1FF0 returns the flag as it stood, then clears the flag and releases the interrupt at the next edge.
- R9: A match that happens while 0x1FF0 is latched leaves the flag at 0. The flag becomes 1 at the first edge where a different address is latched.
- R10: `irqPullLow` is 1 exactly when the flag and the interrupt enable are both 1. While `battMode` is 1, the battery-mode enable must also be 1.
- R11: `pwrUp` clears both enables at the next edge, and a write to 0x1FF0 in the same cycle does not set them. Matches still set the flag during and after `pwrUp`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| pwrUp | input | 1 | Power-up indication, clears the interrupt enables |
| battMode | input | 1 | High while running from the backup supply |
| tickPulse | input | 1 | One-cycle pulse per elapsed second |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curDate | input | 8 | Current day of month, BCD |
| regAddr | input | 13 | Latched register address |
| regRead | input | 1 | Read strobe |
| regWrite | input | 1 | Write enable |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the addressed register |
| irqPullLow | output | 1 | Output enable that pulls the interrupt line low |

## Verification
The hardest case to reach is the held-back alarm. A seconds pulse has to land while the flags address is latched, and the flag must stay hidden through that read. It must then appear only once the address moves. The stimulus parks the address on the flags register, fires a pulse under an always-matching repeat code, and samples the flags register without a read strobe. It then latches an unrelated address for one cycle and returns to look again. Illegal repeat codes and the all-zero disabled setting with an all-zero time are driven on purpose, because those are the cases where a wrong decode would still look plausible.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int NUM_FIELDS = 4;
  localparam int AFE_BIT = 7;
  localparam int AF_BIT  = 6;
  localparam int ABE_BIT = 5;

  typedef enum logic [2:0] {
    RPT_SECOND,
    RPT_MINUTE,
    RPT_HOUR,
    RPT_DAY,
    RPT_MONTH,
    RPT_OFF
  } repeatMode_e;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] wrField;
    logic                  wrFlags;
    logic                  setAf;
    logic                  clrAf;
    logic                  clrEnables;
  } ctrlStrobes_t;

  // significant BCD bits of each time field: sec, min, hour, date
  function automatic int fieldBits(int idx);
    case (idx)
      0, 1:    return 7;
      default: return 6;
    endcase
  endfunction

  // rpt is {date, hour, minute, second}
  function automatic repeatMode_e decodeRepeat(logic [3:0] rpt, logic dateZero);
    case (rpt)
      4'b1110: return RPT_MINUTE;
      4'b1100: return RPT_HOUR;
      4'b1000: return RPT_DAY;
      4'b0000: return dateZero ? RPT_OFF : RPT_MONTH;
      default: return RPT_SECOND;
    endcase
  endfunction

  // which fields must be equal, bit i = field i
  function automatic logic [3:0] neededFields(repeatMode_e mode);
    case (mode)
      RPT_MINUTE: return 4'b0001;
      RPT_HOUR:   return 4'b0011;
      RPT_DAY:    return 4'b0111;
      RPT_MONTH:  return 4'b1111;
      default:    return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/rtc_alarm_datapath.sv
module rtc_alarm_datapath
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobes_t                      strobes,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] curTime,
  input  logic [NUM_FIELDS-1:0]             rdField,
  input  logic                              rdFlags,
  output logic [DATA_W-1:0]                 rdData,
  output logic                              matchNow,
  output logic                              afQ,
  output logic                              afeQ,
  output logic                              abeQ
);

  localparam int DATE_IDX = NUM_FIELDS - 1;
  localparam int DATE_W   = fieldBits(DATE_IDX);

  logic [NUM_FIELDS-1:0]             rptBit;
  logic [NUM_FIELDS-1:0]             fieldEq;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] almVec;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] fieldRd;
  logic [DATA_W-1:0]                 flagsByte;
  logic                              dateZero;
  repeatMode_e                       mode;
  logic [NUM_FIELDS-1:0]             need;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    localparam int FW = fieldBits(gi);
    localparam logic [DATA_W-1:0] MASK = DATA_W'((1 << FW) - 1);
    logic [DATA_W-1:0] almQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) almQ <= '0;
      else if (strobes.wrField[gi]) almQ <= wrData;
    end

    assign almVec[gi]  = almQ;
    assign rptBit[gi]  = almQ[DATA_W-1];
    assign fieldEq[gi] = (curTime[gi] & MASK) == (almQ & MASK);
    assign fieldRd[gi] = rdField[gi] ? almQ : '0;
  end

  assign dateZero = (almVec[DATE_IDX][DATE_W-1:0] == '0);
  assign mode     = decodeRepeat(rptBit, dateZero);
  assign need     = neededFields(mode);
  assign matchNow = (mode != RPT_OFF) && (&(fieldEq | ~need));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) afQ <= 1'b0;
    else if (strobes.clrAf) afQ <= 1'b0;
    else if (strobes.setAf) afQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      afeQ <= 1'b0;
      abeQ <= 1'b0;
    end else if (strobes.clrEnables) begin
      afeQ <= 1'b0;
      abeQ <= 1'b0;
    end else if (strobes.wrFlags) begin
      afeQ <= wrData[AFE_BIT];
      abeQ <= wrData[ABE_BIT];
    end
  end

  always_comb begin
    flagsByte          = '0;
    flagsByte[AFE_BIT] = afeQ;
    flagsByte[AF_BIT]  = afQ;
    flagsByte[ABE_BIT] = abeQ;
    rdData = rdFlags ? flagsByte : '0;
    for (int i = 0; i < NUM_FIELDS; i++) rdData = rdData | fieldRd[i];
  end

endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int              ADDR_W     = 13,
  parameter logic [ADDR_W-1:0] FLAGS_ADDR = 13'h1FF0,
  parameter logic [ADDR_W-1:0] ALARM_BASE = 13'h1FF2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regRead,
  input  logic                  regWrite,
  input  logic                  tickPulse,
  input  logic                  matchNow,
  input  logic                  pwrUp,
  input  logic                  battMode,
  input  logic                  afQ,
  input  logic                  afeQ,
  input  logic                  abeQ,
  output ctrlStrobes_t          strobes,
  output logic [NUM_FIELDS-1:0] rdField,
  output logic                  rdFlags,
  output logic                  irqPullLow
);

  logic pendQ;
  logic alarmEvt;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_dec
    assign rdField[gi] = (regAddr == ADDR_W'(ALARM_BASE + gi));
  end

  assign rdFlags  = (regAddr == FLAGS_ADDR);
  assign alarmEvt = tickPulse & matchNow;

  // an event seen while the flags address is latched waits in pendQ
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= (alarmEvt | pendQ) & rdFlags;
  end

  always_comb begin
    strobes            = '0;
    strobes.wrField    = rdField & {NUM_FIELDS{regWrite}};
    strobes.wrFlags    = regWrite & rdFlags;
    strobes.setAf      = (alarmEvt | pendQ) & ~rdFlags;
    strobes.clrAf      = regRead & rdFlags;
    strobes.clrEnables = pwrUp;
  end

  assign irqPullLow = afQ & afeQ & (~battMode | abeQ);

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_alarm_pkg::*;
#(
  parameter int                ADDR_W     = 13,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] FLAGS_ADDR = 13'h1FF0,
  parameter logic [ADDR_W-1:0] ALARM_BASE = 13'h1FF2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrUp,
  input  logic              battMode,
  input  logic              tickPulse,
  input  logic [DATA_W-1:0] curSec,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curDate,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRead,
  input  logic              regWrite,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqPullLow
);

  ctrlStrobes_t                      strobes;
  logic [NUM_FIELDS-1:0]             rdField;
  logic                              rdFlags;
  logic                              matchNow;
  logic                              afQ;
  logic                              afeQ;
  logic                              abeQ;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] curTime;

  assign curTime = {curDate, curHour, curMin, curSec};

  rtc_alarm_ctrl #(
    .ADDR_W(ADDR_W), .FLAGS_ADDR(FLAGS_ADDR), .ALARM_BASE(ALARM_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRead(regRead),
    .regWrite(regWrite), .tickPulse(tickPulse), .matchNow(matchNow),
    .pwrUp(pwrUp), .battMode(battMode), .afQ(afQ), .afeQ(afeQ), .abeQ(abeQ),
    .strobes(strobes), .rdField(rdField), .rdFlags(rdFlags),
    .irqPullLow(irqPullLow)
  );

  rtc_alarm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWdata),
    .curTime(curTime), .rdField(rdField), .rdFlags(rdFlags),
    .rdData(regRdata), .matchNow(matchNow), .afQ(afQ), .afeQ(afeQ),
    .abeQ(abeQ)
  );

endmodule

// File: rtl/rtc_alarm_checker.sv
module rtc_alarm_checker #(
  parameter int                ADDR_W     = 13,
  parameter logic [ADDR_W-1:0] FLAGS_ADDR = 13'h1FF0
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwrUp,
  input logic              battMode,
  input logic              tickPulse,
  input logic              matchNow,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regRead,
  input logic              afQ,
  input logic              afeQ,
  input logic              abeQ,
  input logic              irqPullLow
);

  logic onFlags;
  assign onFlags = (regAddr == FLAGS_ADDR);

  // R7: a sampled match away from the flags address shows the flag next cycle
  a_r7_tick_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (tickPulse && matchNow && !onFlags) |=> afQ);

  // R8: a strobed read of the flags register clears the flag
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && onFlags) |=> !afQ);

  // R9: no flag may appear while the flags address stays latched
  a_r9_hold_on_flags: assert property (@(posedge clk) disable iff (!rstN)
    (onFlags && !afQ) |=> !afQ);

  // R10: the line is only pulled while the flag is up and enabled
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqPullLow |-> (afQ && afeQ));

  // R10: on backup supply the battery enable is also needed
  a_r10_irq_batt: assert property (@(posedge clk) disable iff (!rstN)
    (battMode && !abeQ) |-> !irqPullLow);

  // R11: power-up drops both enables
  a_r11_pwrup_clears: assert property (@(posedge clk) disable iff (!rstN)
    pwrUp |=> (!afeQ && !abeQ));

endmodule

bind rtc_alarm_top rtc_alarm_checker #(
  .ADDR_W(ADDR_W), .FLAGS_ADDR(FLAGS_ADDR)
) u_checker (
  .clk(clk), .rstN(rstN), .pwrUp(pwrUp), .battMode(battMode),
  .tickPulse(tickPulse), .matchNow(matchNow), .regAddr(regAddr),
  .regRead(regRead), .afQ(afQ), .afeQ(afeQ), .abeQ(abeQ),
  .irqPullLow(irqPullLow)
);

// File: tb/test_rtc_alarm_top.sv
`timescale 1ns/1ps
module test_rtc_alarm_top;

  localparam int FLAGS = 'h1FF0;
  localparam int ASEC  = 'h1FF2;
  localparam int AMIN  = 'h1FF3;
  localparam int AHOUR = 'h1FF4;
  localparam int ADATE = 'h1FF5;
  localparam int OTHER = 'h0100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pwrUp = 1'b0;
  logic        battMode = 1'b0;
  logic        tickPulse = 1'b0;
  logic [7:0]  curSec = 8'h00, curMin = 8'h00, curHour = 8'h00, curDate = 8'h00;
  logic [12:0] regAddr = 13'(OTHER);
  logic        regRead = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regWdata = 8'h00;
  logic [7:0]  regRdata;
  logic        irqPullLow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_alarm_top i_rtc_alarm_top (
    .clk(clk), .rstN(rstN), .pwrUp(pwrUp), .battMode(battMode),
    .tickPulse(tickPulse), .curSec(curSec), .curMin(curMin),
    .curHour(curHour), .curDate(curDate), .regAddr(regAddr),
    .regRead(regRead), .regWrite(regWrite), .regWdata(regWdata),
    .regRdata(regRdata), .irqPullLow(irqPullLow)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int mReg[4];          // sec, min, hour, date
  int mAf, mAfe, mAbe, mWaiting;

  function automatic int curField(int k);
    case (k)
      0: return int'(curSec);
      1: return int'(curMin);
      2: return int'(curHour);
      default: return int'(curDate);
    endcase
  endfunction

  function automatic bit modelHit();
    int code, need;
    int widthMask[4] = '{127, 127, 63, 63};
    code = ((mReg[3] >> 7) << 3) | ((mReg[2] >> 7) << 2) |
           ((mReg[1] >> 7) << 1) | (mReg[0] >> 7);
    if (code == 0 && (mReg[3] & 63) == 0) return 0;
    case (code)
      15: need = 0;
      14: need = 1;
      12: need = 2;
      8:  need = 3;
      0:  need = 4;
      default: need = 0;
    endcase
    for (int k = 0; k < need; k++)
      if ((curField(k) & widthMask[k]) != (mReg[k] & widthMask[k])) return 0;
    return 1;
  endfunction

  function automatic int modelRead();
    int a = int'(regAddr);
    if (a == FLAGS) return (mAfe << 7) | (mAf << 6) | (mAbe << 5);
    if (a >= ASEC && a <= ADATE) return mReg[a - ASEC];
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 4; k++) mReg[k] = 0;
      mAf = 0; mAfe = 0; mAbe = 0; mWaiting = 0;
    end else begin
      bit onF, evt;
      onF = (int'(regAddr) == FLAGS);
      evt = tickPulse && modelHit();
      if (regRead && onF) mAf = 0;
      if (evt || mWaiting) begin
        if (onF) mWaiting = 1;
        else begin mAf = 1; mWaiting = 0; end
      end
      if (regWrite && int'(regAddr) >= ASEC && int'(regAddr) <= ADATE)
        mReg[int'(regAddr) - ASEC] = int'(regWdata);
      if (pwrUp) begin mAfe = 0; mAbe = 0; end
      else if (regWrite && onF) begin
        mAfe = regWdata[7];
        mAbe = regWdata[5];
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (rstN && !done) begin
      check("R2 per-cycle read data", int'(regRdata), modelRead());
      check("R10 per-cycle interrupt", int'(irqPullLow),
            int'(mAf && mAfe && (!battMode || mAbe)));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(int addr, int data);
    @(negedge clk);
    regAddr = 13'(addr); regWrite = 1'b1; regWdata = 8'(data);
    @(negedge clk);
    regWrite = 1'b0; regAddr = 13'(OTHER);
  endtask

  task automatic setAlarm(int s, int m, int h, int d);
    wr(ASEC, s); wr(AMIN, m); wr(AHOUR, h); wr(ADATE, d);
  endtask

  task automatic tick(int s, int m, int h, int d);
    @(negedge clk);
    curSec = 8'(s); curMin = 8'(m); curHour = 8'(h); curDate = 8'(d);
    tickPulse = 1'b1;
    @(negedge clk);
    tickPulse = 1'b0;
  endtask

  task automatic peek(int addr, output int v);
    @(negedge clk);
    regAddr = 13'(addr);
    #1 v = int'(regRdata);
  endtask

  task automatic clearFlag();
    @(negedge clk);
    regAddr = 13'(FLAGS); regRead = 1'b1;
    @(negedge clk);
    regRead = 1'b0; regAddr = 13'(OTHER);
  endtask

  task automatic expectAf(string tag, int exp);
    int v;
    peek(FLAGS, v);
    check(tag, (v >> 6) & 1, exp);
    @(negedge clk);
    regAddr = 13'(OTHER);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    #1;
    check("R1 irq released in reset", int'(irqPullLow), 0);
    rstN = 1'b1;
    peek(FLAGS, v); check("R1 flags after reset", v, 0);
    peek(ADATE, v); check("R1 date alarm after reset", v, 0);

    // R6: disabled setting never matches, even at all-zero time
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    expectAf("R6 disabled alarm stays quiet", 0);

    // R2: register access
    wr(AMIN, 'h45);
    peek(AMIN, v); check("R2 minute alarm readback", v, 'h45);
    peek('h1FF1, v); check("R2 unused address reads zero", v, 0);
    wr(FLAGS, 'hFF);
    peek(FLAGS, v); check("R2 flag write touches enables only", v, 'hA0);
    wr(FLAGS, 'h00);

    // R3: every-second and an illegal code
    setAlarm('h80, 'h80, 'h80, 'h80);
    tick('h12, 'h34, 'h05, 'h17);
    expectAf("R3 code 1111 fires", 1);
    clearFlag();
    setAlarm('h00, 'h80, 'h00, 'h80);
    tick('h59, 'h01, 'h02, 'h03);
    expectAf("R3 illegal code 1010 fires", 1);

    // R8: read returns the flag, then clears it
    @(negedge clk); regAddr = 13'(FLAGS); regRead = 1'b1;
    #1 check("R8 read returns set flag", (int'(regRdata) >> 6) & 1, 1);
    @(negedge clk); regRead = 1'b0;
    #1 check("R8 flag gone after read", (int'(regRdata) >> 6) & 1, 0);
    check("R8 irq released after read", int'(irqPullLow), 0);
    @(negedge clk); regAddr = 13'(OTHER);

    // R4: once per minute
    setAlarm('h30, 'h80, 'h80, 'h80);
    tick('h29, 'h00, 'h00, 'h01);
    expectAf("R4 minute mode wrong second", 0);
    // R7: matching time without a pulse does nothing
    @(negedge clk); curSec = 8'h30;
    repeat (4) @(negedge clk);
    expectAf("R7 no pulse no flag", 0);
    tick('h30, 'h00, 'h00, 'h01);
    expectAf("R4 minute mode match", 1);
    clearFlag();

    // R4: once per hour
    setAlarm('h30, 'h15, 'h80, 'h80);
    tick('h30, 'h16, 'h00, 'h01);
    expectAf("R4 hour mode wrong minute", 0);
    tick('h30, 'h15, 'h07, 'h01);
    expectAf("R4 hour mode match", 1);
    clearFlag();

    // R4: once per day
    setAlarm('h30, 'h15, 'h08, 'h80);
    tick('h30, 'h15, 'h09, 'h01);
    expectAf("R4 day mode wrong hour", 0);
    tick('h30, 'h15, 'h08, 'h28);
    expectAf("R4 day mode match", 1);
    clearFlag();

    // R5: once per month
    setAlarm('h30, 'h15, 'h08, 'h21);
    tick('h30, 'h15, 'h08, 'h22);
    expectAf("R5 month mode wrong date", 0);
    tick('h30, 'h15, 'h08, 'h21);
    expectAf("R5 month mode match", 1);
    clearFlag();

    // R9: event while flags address latched is held back
    setAlarm('h80, 'h80, 'h80, 'h80);
    @(negedge clk); regAddr = 13'(FLAGS); tickPulse = 1'b1;
    @(negedge clk); tickPulse = 1'b0;
    #1 check("R9 flag held while address latched", (int'(regRdata) >> 6) & 1, 0);
    @(negedge clk); regAddr = 13'(OTHER);
    @(negedge clk); regAddr = 13'(FLAGS);
    #1 check("R9 flag after address moved", (int'(regRdata) >> 6) & 1, 1);
    @(negedge clk); regAddr = 13'(OTHER);
    clearFlag();

    // R10: interrupt gating
    wr(FLAGS, 'h80);
    tick('h01, 'h01, 'h01, 'h01);
    #1 check("R10 irq with enable", int'(irqPullLow), 1);
    @(negedge clk); battMode = 1'b1;
    #1 check("R10 irq blocked on battery", int'(irqPullLow), 0);
    wr(FLAGS, 'hA0);
    #1 check("R10 irq on battery with both enables", int'(irqPullLow), 1);
    @(negedge clk); battMode = 1'b0;
    clearFlag();

    // R11: power-up clears enables, flag still sets
    @(negedge clk); pwrUp = 1'b1; regAddr = 13'(FLAGS); regWrite = 1'b1; regWdata = 8'hA0;
    @(negedge clk); pwrUp = 1'b0; regWrite = 1'b0;
    #1 check("R11 enables cleared", int'(regRdata), 0);
    @(negedge clk); regAddr = 13'(OTHER);
    tick('h02, 'h02, 'h02, 'h02);
    #1 check("R11 no irq after power-up", int'(irqPullLow), 0);
    expectAf("R11 flag still recorded", 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule